// File: doc/BRIEF.md
# Register Branch Control Unit

This unit resolves the unconditional branches whose target comes from a general register in a 32-bit soft processor. Each cycle it receives an instruction word with a valid strobe, the PC of that instruction and the value read from the branch source register. It returns the address the fetch stage must use next, a strobe saying that this address is a redirect, a flag marking a delay-slot instruction, an illegal-instruction flag, and a link write-back request (data, destination index, enable) for the register file. It also exports the source register index so that the register file can supply the operand.

One opcode covers every variant. Three option bits in the variant field are decoded independently: one selects absolute targeting instead of PC-relative targeting, one requests that the old PC be written to a destination register, and one requests a single delay slot. With a delay slot the target is computed and held while the branch retires. The redirect is then raised while the next valid instruction is presented, and that instruction still executes. Cycles without a valid instruction between the branch and its slot do not consume the slot.

Top module: `reg_branch_unit`

## Requirements
- R1: Reset clears any pending delayed redirect. A cycle with `instrValid` low never raises `branchTaken`, `delaySlot`, `linkWe` or `illegalInstr`, and `nextPc` is always `curPc + 4` unless a redirect is raised.
- R2: Fields, counting bit 31 as the most significant: opcode `instr[31:26]` must equal 6'b100110. Destination index is `instr[25:21]`. Variant is `instr[20:16]`. Source index `instr[15:11]` appears on `rbIdx`. `instr[10:0]` must be zero.
- R3: Variant 5'b00000 (PC-relative, immediate) raises `branchTaken` in the same cycle, with `nextPc = curPc + rbValue` modulo 2^32.
- R4: Variant 5'b01000 (absolute, immediate) raises `branchTaken` in the same cycle, with `nextPc = rbValue`.
- R5: Variants 5'b10000 (relative), 5'b11000 (absolute) and 5'b10100 (relative with link) are delayed. In the branch cycle `branchTaken` stays low and `nextPc = curPc + 4`. During the next valid instruction `delaySlot` and `branchTaken` are high, and `nextPc` is the target computed from the branch's own PC and operand.
- R6: Cycles with `instrValid` low between a delayed branch and its slot keep the redirect pending without raising it.
- R7: Only variant 5'b10100 raises `linkWe`, in its own cycle, with `linkIdx = instr[25:21]` and `linkData = curPc`.
- R8: A branch-opcode word with nonzero `instr[10:0]` or an unlisted variant (for example 5'b00100, 5'b01100, 5'b11100, 5'b00001) raises `illegalInstr`. It gives no redirect, no link and no pending slot.
- R9: A branch-opcode word presented in a delay slot raises `illegalInstr`. Its own redirect, link and delay are suppressed, and the pending redirect still fires.
- R10: A word with any other opcode gives no redirect, no link, no illegal flag and arms no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| curPc | input | 32 | PC of the presented instruction |
| rbValue | input | 32 | Value of the branch source register |
| rbIdx | output | 5 | Branch source register index for the register file |
| nextPc | output | 32 | Address to fetch next |
| branchTaken | output | 1 | `nextPc` is a redirect |
| delaySlot | output | 1 | The presented instruction is a delay slot |
| illegalInstr | output | 1 | Malformed branch encoding or branch in a delay slot |
| linkWe | output | 1 | Link write-back enable |
| linkIdx | output | 5 | Link destination register index |
| linkData | output | 32 | Link value (branch PC) |

## Verification
Two functions can fall in one cycle: a held redirect firing in a delay slot, and the decode of a new branch in that same slot. The bench arms an absolute delayed branch and then places a linking branch in the slot. The redirect must go to the held address with `delaySlot` and `illegalInstr` both high and no link write. On the following instruction nothing may fire, which shows that the slot branch armed nothing. A second overlap puts stall cycles between the branch and its slot. Redirect and slot flag must appear only when a valid instruction arrives.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int VAR_W     = 5;
  localparam int TAIL_W    = 11;

  localparam logic [5:0] REG_BRANCH_OPCODE = 6'b100110;

  localparam logic [VAR_W-1:0] VAR_REL       = 5'b00000;
  localparam logic [VAR_W-1:0] VAR_REL_DLY   = 5'b10000;
  localparam logic [VAR_W-1:0] VAR_REL_DLY_L = 5'b10100;
  localparam logic [VAR_W-1:0] VAR_ABS       = 5'b01000;
  localparam logic [VAR_W-1:0] VAR_ABS_DLY   = 5'b11000;

  typedef struct packed {
    logic                 isBranchOp;
    logic                 tailZero;
    logic                 knownVariant;
    logic                 delayFlag;
    logic                 absFlag;
    logic                 linkFlag;
    logic [REG_IDX_W-1:0] rdIdx;
    logic [REG_IDX_W-1:0] srcIdx;
  } decodedInstr_t;

  typedef struct packed {
    logic fireNow;
    logic fireSaved;
    logic captureTarget;
    logic selAbs;
    logic linkWe;
  } dpStrobe_t;
endpackage

// File: rtl/rbu_decode.sv
module rbu_decode
  import rbu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decodedInstr_t      dec
);
  logic [VAR_W-1:0] variantField;

  assign variantField = instr[20:16];

  always_comb begin
    dec.isBranchOp = (instr[31:26] == REG_BRANCH_OPCODE);
    dec.tailZero   = (instr[TAIL_W-1:0] == '0);
    unique case (variantField)
      VAR_REL, VAR_REL_DLY, VAR_REL_DLY_L, VAR_ABS, VAR_ABS_DLY:
        dec.knownVariant = 1'b1;
      default:
        dec.knownVariant = 1'b0;
    endcase
    dec.delayFlag = variantField[4];
    dec.absFlag   = variantField[3];
    dec.linkFlag  = variantField[2];
    dec.rdIdx     = instr[25:21];
    dec.srcIdx    = instr[15:11];
  end

  always_comb begin
    if (dec.knownVariant) begin
      assert_link_implies_delay_R7: assert (!dec.linkFlag || dec.delayFlag);
    end
  end
endmodule

// File: rtl/rbu_control.sv
module rbu_control
  import rbu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrValid,
  input  decodedInstr_t        dec,
  output dpStrobe_t            strobe,
  output logic                 branchTaken,
  output logic                 delaySlot,
  output logic                 illegalInstr,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkIdx
);
  logic pending;
  logic inSlot;
  logic wellFormed;
  logic acceptNew;

  always_comb begin
    inSlot     = pending && instrValid;
    wellFormed = dec.isBranchOp && dec.tailZero && dec.knownVariant;
    acceptNew  = instrValid && wellFormed && !inSlot;

    strobe.fireSaved     = inSlot;
    strobe.fireNow       = acceptNew && !dec.delayFlag;
    strobe.captureTarget = acceptNew && dec.delayFlag;
    strobe.selAbs        = dec.absFlag;
    strobe.linkWe        = acceptNew && dec.linkFlag;

    branchTaken  = strobe.fireNow || strobe.fireSaved;
    delaySlot    = inSlot;
    illegalInstr = instrValid && dec.isBranchOp && (!wellFormed || inSlot);
    linkWe       = strobe.linkWe;
    linkIdx      = strobe.linkWe ? dec.rdIdx : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.captureTarget) begin
      pending <= 1'b1;
    end else if (inSlot) begin
      pending <= 1'b0;
    end
  end

  assert_single_action_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.fireNow, strobe.fireSaved, strobe.captureTarget}));

  assert_stall_keeps_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !instrValid) |=> pending);

  assert_slot_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    delaySlot |=> !delaySlot);
endmodule

// File: rtl/rbu_datapath.sv
module rbu_datapath
  import rbu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] rbValue,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkData
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  logic [XLEN-1:0] target;
  logic [XLEN-1:0] savedTarget;
  logic [XLEN-1:0] seqPc;

  always_comb begin
    seqPc  = curPc + STEP;
    target = strobe.selAbs ? rbValue : (curPc + rbValue);
    if (strobe.fireSaved) begin
      nextPc = savedTarget;
    end else if (strobe.fireNow) begin
      nextPc = target;
    end else begin
      nextPc = seqPc;
    end
    linkData = strobe.linkWe ? curPc : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedTarget <= '0;
    end else if (strobe.captureTarget) begin
      savedTarget <= target;
    end
  end

  assert_link_value_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.linkWe |-> (linkData == curPc));

  assert_quiet_sequential_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.fireNow && !strobe.fireSaved) |-> (nextPc == seqPc));
endmodule

// File: rtl/reg_branch_unit.sv
module reg_branch_unit
  import rbu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrValid,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [XLEN-1:0]      curPc,
  input  logic [XLEN-1:0]      rbValue,
  output logic [REG_IDX_W-1:0] rbIdx,
  output logic [XLEN-1:0]      nextPc,
  output logic                 branchTaken,
  output logic                 delaySlot,
  output logic                 illegalInstr,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkIdx,
  output logic [XLEN-1:0]      linkData
);
  decodedInstr_t dec;
  dpStrobe_t     strobe;

  rbu_decode uDecode (
    .instr (instr),
    .dec   (dec)
  );

  assign rbIdx = dec.srcIdx;

  rbu_control uControl (
    .clk          (clk),
    .rstN         (rstN),
    .instrValid   (instrValid),
    .dec          (dec),
    .strobe       (strobe),
    .branchTaken  (branchTaken),
    .delaySlot    (delaySlot),
    .illegalInstr (illegalInstr),
    .linkWe       (linkWe),
    .linkIdx      (linkIdx)
  );

  rbu_datapath #(
    .XLEN    (XLEN),
    .PC_STEP (PC_STEP)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curPc    (curPc),
    .rbValue  (rbValue),
    .nextPc   (nextPc),
    .linkData (linkData)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> (!branchTaken && !delaySlot && !linkWe && !illegalInstr));

  assert_illegal_no_effect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (illegalInstr && !delaySlot) |-> (!branchTaken && !linkWe));

  assert_slot_no_link_R9: assert property (@(posedge clk) disable iff (!rstN)
    delaySlot |-> (!linkWe && branchTaken));
endmodule

// File: tb/tb_reg_branch_unit.sv
module tb_reg_branch_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        instrValid;
  logic [31:0] instr;
  logic [31:0] curPc;
  logic [31:0] rbValue;
  logic [4:0]  rbIdx;
  logic [31:0] nextPc;
  logic        branchTaken;
  logic        delaySlot;
  logic        illegalInstr;
  logic        linkWe;
  logic [4:0]  linkIdx;
  logic [31:0] linkData;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  reg_branch_unit dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .curPc(curPc), .rbValue(rbValue), .rbIdx(rbIdx), .nextPc(nextPc),
    .branchTaken(branchTaken), .delaySlot(delaySlot), .illegalInstr(illegalInstr),
    .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData)
  );

  function automatic logic [31:0] mk(input logic [4:0] rd, input logic [4:0] v,
                                     input logic [4:0] rb, input logic [10:0] lo);
    return {6'b100110, rd, v, rb, lo};
  endfunction

  localparam logic [31:0] NOP = 32'h0000_0000;
  localparam int K_NOW = 0, K_DLY = 1, K_ILL = 2, K_OTHER = 3;

  typedef struct packed {
    logic [31:0] w;
    logic [31:0] pc;
    logic [31:0] rb;
    logic [1:0]  kind;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{mk(5'd0,  5'b00000, 5'd3, 11'd0), 32'h0000_0100, 32'h0000_0040, 2'(K_NOW)},
    '{mk(5'd0,  5'b00000, 5'd4, 11'd0), 32'h0000_1000, 32'hFFFF_FFF0, 2'(K_NOW)},
    '{mk(5'd0,  5'b01000, 5'd5, 11'd0), 32'h0000_0200, 32'h0000_8000, 2'(K_NOW)},
    '{mk(5'd0,  5'b10000, 5'd6, 11'd0), 32'h0000_0300, 32'h0000_0020, 2'(K_DLY)},
    '{mk(5'd0,  5'b11000, 5'd7, 11'd0), 32'h0000_0400, 32'h0000_ABC0, 2'(K_DLY)},
    '{mk(5'd15, 5'b10100, 5'd8, 11'd0), 32'h0000_0500, 32'h0000_0100, 2'(K_DLY)},
    '{mk(5'd0,  5'b00000, 5'd3, 11'h001), 32'h0000_0600, 32'h0000_0010, 2'(K_ILL)},
    '{mk(5'd2,  5'b00100, 5'd3, 11'd0), 32'h0000_0610, 32'h0000_0010, 2'(K_ILL)},
    '{mk(5'd2,  5'b01100, 5'd3, 11'd0), 32'h0000_0620, 32'h0000_0010, 2'(K_ILL)},
    '{mk(5'd0,  5'b00001, 5'd3, 11'd0), 32'h0000_0630, 32'h0000_0010, 2'(K_ILL)},
    '{mk(5'd31, 5'b11100, 5'd3, 11'd0), 32'h0000_0640, 32'h0000_0010, 2'(K_ILL)},
    '{NOP,                              32'h0000_0700, 32'h0000_0010, 2'(K_OTHER)},
    '{{6'b100101, 5'd0, 5'b10000, 5'd3, 11'd0}, 32'h0000_0710, 32'h0000_0010, 2'(K_OTHER)},
    '{mk(5'd0,  5'b00000, 5'd9, 11'd0), 32'hFFFF_FFF0, 32'h0000_0020, 2'(K_NOW)}
  };

  function automatic logic [31:0] refTarget(input logic [31:0] w, input logic [31:0] pc,
                                            input logic [31:0] rb);
    return w[19] ? rb : pc + rb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic v, input logic [31:0] w, input logic [31:0] pc,
                         input logic [31:0] rb);
    @(negedge clk);
    instrValid = v; instr = w; curPc = pc; rbValue = rb;
    #2;
  endtask

  task automatic expectQuiet(input string req, input logic [31:0] pc);
    chk(!branchTaken, req, 32'(branchTaken), 0);
    chk(!delaySlot, req, 32'(delaySlot), 0);
    chk(nextPc == pc + 4, req, nextPc, pc + 4);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    rstN = 1'b0; instrValid = 1'b0; instr = NOP; curPc = 32'h10; rbValue = 0;
    repeat (3) @(posedge clk);
    #2;
    // R1: state under reset
    chk(!branchTaken && !delaySlot && !linkWe && !illegalInstr, "R1 reset outputs",
        {28'd0, branchTaken, delaySlot, linkWe, illegalInstr}, 0);
    chk(nextPc == 32'h14, "R1 reset nextPc", nextPc, 32'h14);
    @(negedge clk); rstN = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [31:0] tgt = refTarget(v.w, v.pc, v.rb);
      bit lnk = (v.kind != 2'(K_ILL)) && (v.kind != 2'(K_OTHER)) && v.w[18];
      present(1'b1, v.w, v.pc, v.rb);
      chk(rbIdx == v.w[15:11], "R2 rbIdx", 32'(rbIdx), 32'(v.w[15:11]));
      case (int'(v.kind))
        K_NOW: begin
          chk(branchTaken, v.w[19] ? "R4 taken" : "R3 taken", 32'(branchTaken), 1);
          chk(nextPc == tgt, v.w[19] ? "R4 nextPc" : "R3 nextPc", nextPc, tgt);
          chk(!linkWe && !illegalInstr, "R7 no link on plain", 32'(linkWe), 0);
        end
        K_DLY: begin
          expectQuiet("R5 branch cycle", v.pc);
          chk(linkWe == lnk, "R7 linkWe", 32'(linkWe), 32'(lnk));
          if (lnk) begin
            chk(linkIdx == v.w[25:21], "R7 linkIdx", 32'(linkIdx), 32'(v.w[25:21]));
            chk(linkData == v.pc, "R7 linkData", linkData, v.pc);
          end
        end
        K_ILL: begin
          chk(illegalInstr, "R8 illegal", 32'(illegalInstr), 1);
          expectQuiet("R8 no redirect", v.pc);
          chk(!linkWe, "R8 no link", 32'(linkWe), 0);
        end
        default: begin
          chk(!illegalInstr && !linkWe, "R10 other opcode", 32'(illegalInstr), 0);
          expectQuiet("R10 no redirect", v.pc);
        end
      endcase
      present(1'b1, NOP, v.pc + 4, 32'h0);
      if (int'(v.kind) == K_DLY) begin
        chk(delaySlot && branchTaken, "R5 slot fires", {30'd0, delaySlot, branchTaken}, 3);
        chk(nextPc == tgt, "R5 slot nextPc", nextPc, tgt);
      end else begin
        expectQuiet("R8 R10 no slot armed", v.pc + 4);
      end
    end

    // R6: stalls between delayed branch and its slot
    present(1'b1, mk(5'd0, 5'b10000, 5'd1, 11'd0), 32'h800, 32'h10);
    present(1'b0, NOP, 32'h804, 32'h0);
    chk(!branchTaken && !delaySlot, "R6 stall 1", 32'(branchTaken), 0);
    present(1'b0, mk(5'd0, 5'b00000, 5'd1, 11'd0), 32'h804, 32'h40);
    chk(!branchTaken && !delaySlot && !illegalInstr, "R6 R1 stall with branch word",
        32'(branchTaken), 0);
    present(1'b1, NOP, 32'h804, 32'h0);
    chk(delaySlot && branchTaken, "R6 slot after stall", 32'(delaySlot), 1);
    chk(nextPc == 32'h810, "R6 nextPc", nextPc, 32'h810);

    // R9: branch inside delay slot
    present(1'b1, mk(5'd0, 5'b11000, 5'd2, 11'd0), 32'h900, 32'h2000);
    present(1'b1, mk(5'd9, 5'b10100, 5'd3, 11'd0), 32'h904, 32'h50);
    chk(delaySlot && branchTaken, "R9 held redirect fires", 32'(branchTaken), 1);
    chk(nextPc == 32'h2000, "R9 nextPc", nextPc, 32'h2000);
    chk(illegalInstr, "R9 illegal", 32'(illegalInstr), 1);
    chk(!linkWe, "R9 link suppressed", 32'(linkWe), 0);
    present(1'b1, NOP, 32'h2000, 32'h0);
    expectQuiet("R9 slot branch armed nothing", 32'h2000);

    // R1: reset drops a pending redirect
    present(1'b1, mk(5'd0, 5'b10000, 5'd1, 11'd0), 32'hA00, 32'h100);
    @(negedge clk); rstN = 1'b0; instrValid = 1'b0;
    @(negedge clk); rstN = 1'b1;
    present(1'b1, NOP, 32'hA04, 32'h0);
    expectQuiet("R1 reset cleared pending", 32'hA04);

    summary();
  end
endmodule